// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block is the execute-stage arithmetic core of a small load/store processor. It takes a 2-bit operation class from the main instruction decoder and the 6-bit function field of a register-type instruction. From these it forms a 3-bit operation select. The select picks one of five operations on two 32-bit operands: bitwise AND, bitwise OR, addition, subtraction and signed set-less-than.

The unit is purely combinational. The result, a flag that is high when the result is all zeros, and the decoded select are all valid in the same cycle as the inputs. Load and store address calculation uses the add class. The equality branch uses the subtract class and tests the zero flag. Register-type instructions pass their function field through for decoding.

Top module: `alu_func_unit`

## Requirements
- R1: Operation class 00 sets the select to 010 (add) whatever the function field holds.
- R2: Operation class 01 sets the select to 110 (subtract) whatever the function field holds.
- R3: Operation class 10 decodes the function field as follows: 0x20 gives 010, 0x22 gives 110, 0x24 gives 000, 0x25 gives 001 and 0x2A gives 111.
- R4: Class 10 with any other function code, and class 11 with any function code, set the select to 011 (no operation), and the result is then zero.
- R5: Select 000 gives the bitwise AND of the two operands.
- R6: Select 001 gives the bitwise OR of the two operands.
- R7: Select 010 gives the sum of the operands modulo 2^32.
- R8: Select 110 gives operand A minus operand B modulo 2^32.
- R9: Select 111 gives 1 when A is less than B, with both read as signed two's-complement values, and gives 0 otherwise. Bits 31..1 of the result are zero.
- R10: The zero flag is high exactly when all 32 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of a register-type instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| alu_sel | output | 3 | Decoded operation select |

## Verification
All three outputs depend only on the present inputs, so every result is due within the cycle in which the stimulus is applied. The bench changes the inputs on the falling clock edge and samples all outputs one nanosecond later, well before the next rising edge, so no registered delay is involved in any check. The bench sweeps every class and function-code pair against the expected select. It then crosses a set of sign-boundary operands with each defined operation. In every one of these vectors it checks the result and the zero flag.

// File: rtl/alu_func_unit.sv
module alu_func_unit #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic [2:0]       alu_sel
);

  localparam logic [2:0] SEL_AND = 3'b000;
  localparam logic [2:0] SEL_OR  = 3'b001;
  localparam logic [2:0] SEL_ADD = 3'b010;
  localparam logic [2:0] SEL_NOP = 3'b011;
  localparam logic [2:0] SEL_SUB = 3'b110;
  localparam logic [2:0] SEL_SLT = 3'b111;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  logic [2:0]       sel;
  logic [WIDTH-1:0] res;
  logic             lt;

  always_comb begin
    unique case (op_class)
      2'b00:   sel = SEL_ADD;
      2'b01:   sel = SEL_SUB;
      2'b10: begin
        case (funct)
          FN_ADD:  sel = SEL_ADD;
          FN_SUB:  sel = SEL_SUB;
          FN_AND:  sel = SEL_AND;
          FN_OR:   sel = SEL_OR;
          FN_SLT:  sel = SEL_SLT;
          default: sel = SEL_NOP;
        endcase
      end
      default: sel = SEL_NOP;
    endcase

    lt = $signed(opnd_a) < $signed(opnd_b);

    case (sel)
      SEL_AND: res = opnd_a & opnd_b;
      SEL_OR:  res = opnd_a | opnd_b;
      SEL_ADD: res = opnd_a + opnd_b;
      SEL_SUB: res = opnd_a - opnd_b;
      SEL_SLT: res = {{(WIDTH-1){1'b0}}, lt};
      default: res = '0;
    endcase

    // Datapath invariants checked against the operands
    a_r4_nop_zero: assert (sel != SEL_NOP || res == '0)
      else $error("R4 undefined select produced nonzero result");
    a_r5_and_subset: assert (sel != SEL_AND || ((res & ~opnd_a) == '0 && (res & ~opnd_b) == '0))
      else $error("R5 AND result has bit outside an operand");
    a_r6_or_superset: assert (sel != SEL_OR || ((res | opnd_a) == res && (res | opnd_b) == res))
      else $error("R6 OR result misses an operand bit");
    a_r7_add_inverse: assert (sel != SEL_ADD || WIDTH'(res - opnd_b) == opnd_a)
      else $error("R7 sum minus B differs from A");
    a_r8_sub_inverse: assert (sel != SEL_SUB || WIDTH'(res + opnd_b) == opnd_a)
      else $error("R8 difference plus B differs from A");
    a_r9_slt_single_bit: assert (sel != SEL_SLT || res[WIDTH-1:1] == '0)
      else $error("R9 set-less-than upper bits nonzero");
    a_r1_class_mem: assert (op_class != 2'b00 || sel == SEL_ADD)
      else $error("R1 memory class did not select add");
    a_r2_class_branch: assert (op_class != 2'b01 || sel == SEL_SUB)
      else $error("R2 branch class did not select subtract");
  end

  assign result  = res;
  assign zero    = ~|res;
  assign alu_sel = sel;

endmodule

// File: tb/test_alu_func_unit.sv
`timescale 1ns/1ps
module test_alu_func_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_class = 2'b00;
  logic [5:0]  funct = 6'h00;
  logic [31:0] opnd_a = 32'h0;
  logic [31:0] opnd_b = 32'h0;
  logic [31:0] result;
  logic        zero;
  logic [2:0]  alu_sel;

  int n_vec  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  alu_func_unit #(.WIDTH(32)) i_alu_func_unit (
    .op_class(op_class), .funct(funct), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .zero(zero), .alu_sel(alu_sel)
  );

  logic [31:0] pats [16] = '{32'h0, 32'h1, 32'h2, 32'hFFFFFFFF, 32'hFFFFFFFE,
                             32'h7FFFFFFF, 32'h80000000, 32'h80000001, 32'h5,
                             32'h7, 32'h12345678, 32'hFEDCBA98, 32'hFFFF0000,
                             32'h0000FFFF, 32'h3, 32'h40000000};

  function automatic logic [2:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    if (c == 2'b11) return 3'b011;
    if (f == 6'h20) return 3'b010;
    if (f == 6'h22) return 3'b110;
    if (f == 6'h24) return 3'b000;
    if (f == 6'h25) return 3'b001;
    if (f == 6'h2A) return 3'b111;
    return 3'b011;
  endfunction

  function automatic logic [31:0] exp_res(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    logic a_neg, b_neg, less;
    a_neg = a[31];
    b_neg = b[31];
    less = (a_neg != b_neg) ? a_neg : (a < b);
    case (s)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b110:  return a + ~b + 32'd1;
      3'b111:  return less ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [2:0]  es;
    logic [31:0] er;
    @(negedge clk);
    op_class = c; funct = f; opnd_a = a; opnd_b = b;
    #1;
    es = exp_sel(c, f);
    er = exp_res(es, a, b);
    n_vec++;
    if (alu_sel !== es || result !== er || zero !== (er == 32'd0)) begin
      n_fail++;
      $display("FAIL %s: class=%b funct=%h a=%h b=%h sel=%b/%b result=%h/%h zero=%b/%b (actual/expected)",
               tag, c, f, a, b, alu_sel, es, result, er, zero, (er == 32'd0));
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs: class 00, zero operands -> add, result 0, zero high (R1, R10)
    apply(2'b00, 6'h00, 32'h0, 32'h0, "R1 R10 initial");
    // full class/function sweep for decoding: R1, R2, R3, R4
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++)
        apply(2'(c), 6'(f), 32'h0000F0F3, 32'h00000F35,
              c == 0 ? "R1" : c == 1 ? "R2" : c == 3 ? "R4" : "R3 R4");
    // operand crosses per operation: R5..R9 plus zero flag R10
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        apply(2'b10, 6'h24, pats[i], pats[j], "R5 R10");
        apply(2'b10, 6'h25, pats[i], pats[j], "R6 R10");
        apply(2'b10, 6'h20, pats[i], pats[j], "R7 R10");
        apply(2'b10, 6'h22, pats[i], pats[j], "R8 R10");
        apply(2'b10, 6'h2A, pats[i], pats[j], "R9 R10");
        apply(2'b00, 6'h2A, pats[i], pats[j], "R1 R7");
        apply(2'b01, 6'h24, pats[i], pats[j], "R2 R8");
        apply(2'b11, 6'h20, pats[i], pats[j], "R4");
      end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule